// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sequences the low-power standby mode of a small controller-style system. It watches two active-low pins, a standby request and a reset request. From them it drives the global internal reset, the oscillator enable, the tri-state control for the I/O pads, a RAM retention flag and a two-bit state code. A low standby request wins over everything else and parks the system in standby from any state. Leaving standby is a two-pin handshake:

1. The standby pin is raised while reset is still held low. This starts the oscillator.
2. Reset may only be released once a counted oscillator settling window has elapsed.
3. The block then spends a fixed number of cycles in reset exception handling before it reports run.

Both pins are asynchronous to the reference clock. Each passes through a two-flop synchronizer before the state machine uses it. The settling window and the exception-handling length are parameters counted in reference-clock cycles.

The block also records two kinds of illegal behaviour, each in a sticky flag. One is a reset released before the oscillator has settled. The other is a change on the mode-select inputs while standby is active. The RAM retention flag is decided at the moment standby is entered. RAM counts as retained only if the RAM-enable control bit was already cleared at that moment.

Top module: `pwr_standby_seq`

## Requirements
- R1: A low level on `stby_n_i` puts the block into standby no later than the third rising clock edge after the pin falls, whatever the current state (run, reset hold or exception handling).
- R2: While in standby, `io_hiz_o` is 1, `sys_rst_o` is 1 and `osc_en_o` is 0.
- R3: On each entry into standby, `ram_keep_o` takes the inverse of `ram_en_i` as sampled at that entry. It holds that value until the next entry. It is 0 after `rst`.
- R4: Raising `stby_n_i` while in standby moves the block to reset hold, with `osc_en_o` at 1 and `sys_rst_o` still at 1.
- R5: `stab_done_o` rises exactly `STAB_CYC` clock cycles after `osc_en_o` rises. It is 0 whenever the oscillator enable has been off during the previous cycle.
- R6: In reset hold, with `stab_done_o` at 1 and a reset release that was not early, a high reset pin moves the block to exception handling. Exception handling lasts exactly `EXC_CYC` cycles with `sys_rst_o` at 0, and the block then moves to run.
- R7: A reset pin seen high in reset hold before `stab_done_o` is 1 has two effects. It keeps the block in reset hold, and it sets the sticky `early_err_o`, which only `rst` clears. After that, the reset pin must go low and high again before exception handling can begin.
- R8: A low reset pin in exception handling or in run returns the block to reset hold. The oscillator stays on and `stab_done_o` stays at 1, so the settling window is not counted again.
- R9: On entry into standby the block latches the synchronized mode-select value. Any difference seen while standby lasts sets the sticky `mode_err_o`. After `rst` no comparison is made until the first entry into standby.
- R10: `state_o` encodes standby as 0, reset hold as 1, exception handling as 2 and run as 3. After `rst` the block is in standby with `ram_keep_o`, `stab_done_o`, `early_err_o` and `mode_err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stby_n_i | input | 1 | Standby request pin, active low, asynchronous |
| res_n_i | input | 1 | Reset request pin, active low, asynchronous |
| mode_i | input | MODE_W | Mode-select inputs that must stay static during standby |
| ram_en_i | input | 1 | RAM-enable control bit, synchronous to `clk` |
| sys_rst_o | output | 1 | Global internal reset to the functional units |
| osc_en_o | output | 1 | Oscillator enable |
| io_hiz_o | output | 1 | Places all I/O pads in high impedance |
| ram_keep_o | output | 1 | RAM contents counted as retained across the last standby |
| state_o | output | 2 | Current power state code |
| stab_done_o | output | 1 | Oscillator settling window has elapsed |
| early_err_o | output | 1 | Sticky: reset released before oscillator settled |
| mode_err_o | output | 1 | Sticky: mode inputs changed during standby |

## Verification
A state register that holds a wrong value shows at the ports within one cycle. All of the pad, reset and oscillator controls are registered from the same next-state value as `state_o`, so they would disagree with the state code at once. A settling counter that is off by one moves the rise of `stab_done_o` by a cycle. It can also let reset hold end a cycle early, which the early-release flag would miss. The bench therefore compares every output against a cycle-accurate expectation on each clock, and times the settling window and the exception-handling length exactly. A wrongly latched mode or RAM retention value stays hidden until the next comparison or standby entry. The scenarios therefore change the mode inputs and toggle the RAM-enable bit inside and around standby.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // Power state codes; the numeric values are visible on state_o.
  typedef enum logic [1:0] {
    PS_STBY = 2'd0,
    PS_HOLD = 2'd1,
    PS_EXC  = 2'd2,
    PS_RUN  = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/pwr_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
module pwr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= '0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_stab_timer.sv
// Counts the oscillator settling window once the enable is on.
module pwr_stab_timer #(
  parameter int STAB_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en_i,
  output logic done_o
);

  localparam int CNT_W = $clog2(STAB_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  // The counter is reloaded while the oscillator is off, so it starts its
  // count on the first cycle the enable is seen high.
  always_ff @(posedge clk) begin
    if (rst || !osc_en_i) begin
      cnt_q  <= CNT_W'(STAB_CYC);
      done_q <= 1'b0;
    end else begin
      if (cnt_q != '0)          cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1))   done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/pwr_mode_guard.sv
// Latches the mode inputs on standby entry and flags later changes.
module pwr_mode_guard #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              in_stby_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              err_o
);

  logic [MODE_W-1:0] lat_q;
  logic              armed_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (enter_i) begin
        lat_q   <= mode_i;
        armed_q <= 1'b1;
      end else if (!in_stby_i) begin
        armed_q <= 1'b0;
      end
      if (in_stby_i && armed_q && (mode_i != lat_q)) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/pwr_standby_seq.sv
// Standby entry and wake sequencer, top level.
module pwr_standby_seq
  import pwr_seq_pkg::*;
#(
  parameter int MODE_W   = 3,
  parameter int STAB_CYC = 1024,
  parameter int EXC_CYC  = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_n_i,
  input  logic              res_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ram_en_i,
  output logic              sys_rst_o,
  output logic              osc_en_o,
  output logic              io_hiz_o,
  output logic              ram_keep_o,
  output logic [1:0]        state_o,
  output logic              stab_done_o,
  output logic              early_err_o,
  output logic              mode_err_o
);

  localparam int EXC_W = $clog2(EXC_CYC + 1);

  logic [1:0]        pins_s;
  logic              stby_s;
  logic              res_s;
  logic [MODE_W-1:0] mode_s;

  pwr_state_e        state_q, state_d;
  logic [EXC_W-1:0]  exc_q;
  logic              hold_bad_q;
  logic              early_q;
  logic              keep_q;
  logic              srst_q, osc_q, hiz_q;
  logic              done;
  logic              enter_stby;
  logic              early_hit;

  // Pin synchronizers
  pwr_sync #(.W(2), .STAGES(SYNC_STG)) pin_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({stby_n_i, res_n_i}),
    .q_o (pins_s)
  );

  pwr_sync #(.W(MODE_W), .STAGES(SYNC_STG)) mode_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (mode_i),
    .q_o (mode_s)
  );

  assign stby_s = pins_s[1];
  assign res_s  = pins_s[0];

  // Oscillator settling timer
  pwr_stab_timer #(.STAB_CYC(STAB_CYC)) stab_i (
    .clk      (clk),
    .rst      (rst),
    .osc_en_i (osc_q),
    .done_o   (done)
  );

  // Next-state logic; standby request has priority over all else.
  always_comb begin
    state_d = state_q;
    if (!stby_s) begin
      state_d = PS_STBY;
    end else begin
      case (state_q)
        PS_STBY: state_d = PS_HOLD;
        PS_HOLD: if (res_s && done && !hold_bad_q) state_d = PS_EXC;
        PS_EXC: begin
          if (!res_s)            state_d = PS_HOLD;
          else if (exc_q == '0)  state_d = PS_RUN;
        end
        PS_RUN:  if (!res_s) state_d = PS_HOLD;
        default: state_d = PS_STBY;
      endcase
    end
  end

  assign enter_stby = (state_d == PS_STBY) && (state_q != PS_STBY);
  assign early_hit  = (state_q == PS_HOLD) && res_s && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_STBY;
      exc_q      <= '0;
      hold_bad_q <= 1'b0;
      early_q    <= 1'b0;
      keep_q     <= 1'b0;
      srst_q     <= 1'b1;
      osc_q      <= 1'b0;
      hiz_q      <= 1'b1;
    end else begin
      state_q <= state_d;

      if ((state_d == PS_EXC) && (state_q != PS_EXC))
        exc_q <= EXC_W'(EXC_CYC - 1);
      else if ((state_q == PS_EXC) && (exc_q != '0))
        exc_q <= exc_q - 1'b1;

      if (!res_s)         hold_bad_q <= 1'b0;
      else if (early_hit) hold_bad_q <= 1'b1;

      if (early_hit)  early_q <= 1'b1;
      if (enter_stby) keep_q  <= !ram_en_i;

      srst_q <= (state_d == PS_STBY) || (state_d == PS_HOLD);
      osc_q  <= (state_d != PS_STBY);
      hiz_q  <= (state_d == PS_STBY);
    end
  end

  // Mode-select guard
  pwr_mode_guard #(.MODE_W(MODE_W)) mode_guard_i (
    .clk       (clk),
    .rst       (rst),
    .enter_i   (enter_stby),
    .in_stby_i (state_q == PS_STBY),
    .mode_i    (mode_s),
    .err_o     (mode_err_o)
  );

  assign sys_rst_o   = srst_q;
  assign osc_en_o    = osc_q;
  assign io_hiz_o    = hiz_q;
  assign ram_keep_o  = keep_q;
  assign state_o     = state_q;
  assign stab_done_o = done;
  assign early_err_o = early_q;

endmodule

// File: rtl/pwr_standby_seq_chk.sv
// Property checker, bound into the sequencer top.
module pwr_standby_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       stby_s,
  input logic [1:0] state_o,
  input logic       sys_rst_o,
  input logic       osc_en_o,
  input logic       io_hiz_o,
  input logic       stab_done_o,
  input logic       early_err_o,
  input logic       mode_err_o
);

  p_stby_entry_r1: assert property (@(posedge clk) disable iff (rst)
    !stby_s |=> (state_o == 2'd0));

  p_stby_outputs_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (io_hiz_o && sys_rst_o && !osc_en_o));

  p_osc_rise_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en_o) |-> (state_o == 2'd1));

  p_done_off_r5: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |=> !stab_done_o);

  p_no_exc_unsettled_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 2'd1) && !stab_done_o) |=> (state_o != 2'd2));

  p_run_after_exc_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 2'd3) && ($past(state_o) != 2'd3)) |-> ($past(state_o) == 2'd2));

  p_early_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    early_err_o |=> early_err_o);

  p_mode_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    mode_err_o |=> mode_err_o);

endmodule

bind pwr_standby_seq pwr_standby_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .stby_s      (stby_s),
  .state_o     (state_o),
  .sys_rst_o   (sys_rst_o),
  .osc_en_o    (osc_en_o),
  .io_hiz_o    (io_hiz_o),
  .stab_done_o (stab_done_o),
  .early_err_o (early_err_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/pwr_standby_seq_tb.sv
module pwr_standby_seq_tb_top;

  localparam int MODE_W = 3;
  localparam int STAB   = 40;
  localparam int EXC    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              stby_n = 1'b0;
  logic              res_n  = 1'b0;
  logic [MODE_W-1:0] mode   = '0;
  logic              ram_en = 1'b1;
  logic              sys_rst, osc_en, io_hiz, ram_keep;
  logic [1:0]        state;
  logic              stab_done, early_err, mode_err;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwr_standby_seq #(
    .MODE_W(MODE_W), .STAB_CYC(STAB), .EXC_CYC(EXC), .SYNC_STG(2)
  ) dut_i (
    .clk(clk), .rst(rst), .stby_n_i(stby_n), .res_n_i(res_n),
    .mode_i(mode), .ram_en_i(ram_en),
    .sys_rst_o(sys_rst), .osc_en_o(osc_en), .io_hiz_o(io_hiz),
    .ram_keep_o(ram_keep), .state_o(state), .stab_done_o(stab_done),
    .early_err_o(early_err), .mode_err_o(mode_err)
  );

  // Expected-value model, advanced once per clock from the requirements.
  logic              m_s1, m_s2, m_r1, m_r2;
  logic [MODE_W-1:0] m_m1, m_m2, m_lat;
  int                m_state, m_exc, m_cnt;
  logic              m_done, m_bad, m_early, m_keep, m_armed, m_merr;
  logic              m_osc, m_hiz, m_srst;

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_r1 = 0; m_r2 = 0; m_m1 = '0; m_m2 = '0; m_lat = '0;
    m_state = 0; m_exc = 0; m_cnt = STAB; m_done = 0; m_bad = 0;
    m_early = 0; m_keep = 0; m_armed = 0; m_merr = 0;
    m_osc = 0; m_hiz = 1; m_srst = 1;
  endtask

  task automatic model_step();
    int   ns;
    logic enter, in_stby;
    if (!m_s2) ns = 0;
    else begin
      case (m_state)
        0: ns = 1;
        1: ns = (m_r2 && m_done && !m_bad) ? 2 : 1;
        2: ns = !m_r2 ? 1 : ((m_exc == 0) ? 3 : 2);
        default: ns = !m_r2 ? 1 : 3;
      endcase
    end
    enter   = (ns == 0) && (m_state != 0);
    in_stby = (m_state == 0);
    // mode guard
    if (in_stby && m_armed && (m_m2 != m_lat)) m_merr = 1;
    if (enter) begin m_lat = m_m2; m_armed = 1; end
    else if (!in_stby) m_armed = 0;
    // settling timer (sees the enable of the previous cycle)
    if (!m_osc) begin m_cnt = STAB; m_done = 0; end
    else begin
      if (m_cnt == 1) m_done = 1;
      if (m_cnt != 0) m_cnt = m_cnt - 1;
    end
    // early release tracking (uses the settled flag before this edge)
    // m_done was updated above, so use its pre-edge value captured below
    m_exc = ((ns == 2) && (m_state != 2)) ? EXC - 1 :
            ((m_state == 2) && (m_exc != 0)) ? m_exc - 1 : m_exc;
    if (enter) m_keep = !ram_en;
    m_osc = (ns != 0); m_hiz = (ns == 0); m_srst = (ns <= 1);
    m_state = ns;
    m_s2 = m_s1; m_s1 = stby_n; m_r2 = m_r1; m_r1 = res_n;
    m_m2 = m_m1; m_m1 = mode;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10 state code", int'(state), m_state);
    chk("R2 io_hiz", int'(io_hiz), int'(m_hiz));
    chk("R6 sys_rst", int'(sys_rst), int'(m_srst));
    chk("R4 osc_en", int'(osc_en), int'(m_osc));
    chk("R3 ram_keep", int'(ram_keep), int'(m_keep));
    chk("R5 stab_done", int'(stab_done), int'(m_done));
    chk("R7 early_err", int'(early_err), int'(m_early));
    chk("R9 mode_err", int'(mode_err), int'(m_merr));
  endtask

  task automatic tick();
    logic pre_done, pre_r, hold;
    pre_done = m_done; pre_r = m_r2; hold = (m_state == 1);
    @(posedge clk);
    @(negedge clk);
    // early-release flags depend on pre-edge values
    if (!pre_r) m_bad = 0;
    else if (hold && !pre_done) begin m_bad = 1; m_early = 1; end
    model_step();
    compare_all();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_state(input int st, input int maxc);
    for (int i = 0; i < maxc && int'(state) != st; i++) tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 reset state", int'(state), 0);
    chk("R10 reset flags", int'({ram_keep, stab_done, early_err, mode_err}), 0);
    chk("R2 reset pads", int'({io_hiz, sys_rst, osc_en}), 3'b110);
    tick_n(4);

    // R4/R5: release standby with reset held
    stby_n = 1'b1;
    wait_state(1, 10);
    chk("R4 hold after standby release", int'(state), 1);
    chk("R4 osc on in hold", int'(osc_en), 1);
    cnt = 0;
    while (!stab_done && cnt < STAB + 10) begin tick(); cnt++; end
    chk("R5 settle window length", cnt, STAB);

    // R6: normal release and exception-handling length
    res_n = 1'b1;
    wait_state(2, 10);
    cnt = 0;
    while (int'(state) == 2 && cnt < EXC + 10) begin tick(); cnt++; end
    chk("R6 exception length", cnt, EXC);
    chk("R6 run after exception", int'(state), 3);
    tick_n(5);

    // R8: reset from run, no new settle window
    res_n = 1'b0;
    wait_state(1, 10);
    chk("R8 hold from run", int'(state), 1);
    chk("R8 settle kept", int'(stab_done), 1);
    tick_n(3);
    res_n = 1'b1;
    wait_state(3, 20);
    chk("R8 back to run", int'(state), 3);

    // R3/R9: ordered entry with RAM enable cleared, then mode change
    ram_en = 1'b0;
    res_n = 1'b0;
    tick_n(4);
    stby_n = 1'b0;
    tick_n(4);
    chk("R3 keep after cleared enable", int'(ram_keep), 1);
    ram_en = 1'b1;
    tick_n(3);
    chk("R3 keep holds", int'(ram_keep), 1);
    chk("R9 no error while static", int'(mode_err), 0);
    mode = 3'b101;
    tick_n(5);
    chk("R9 mode change flagged", int'(mode_err), 1);

    // R7: reset released too early
    stby_n = 1'b1;
    res_n = 1'b1;
    tick_n(8);
    chk("R7 early flag", int'(early_err), 1);
    chk("R7 still holding", int'(state), 1);
    tick_n(STAB + 5);
    chk("R7 hold after settle", int'(state), 1);
    res_n = 1'b0;
    tick_n(3);
    res_n = 1'b1;
    wait_state(3, 20);
    chk("R7 re-release reaches run", int'(state), 3);

    // R1: entry from run with no reset first, exact latency
    stby_n = 1'b0;
    tick_n(2);
    chk("R1 not yet in standby", int'(state), 3);
    tick();
    chk("R1 standby on third edge", int'(state), 0);
    chk("R3 keep with enable set", int'(ram_keep), 0);

    // Constrained random pin activity
    for (int seg = 0; seg < 70; seg++) begin
      stby_n = ($urandom_range(0, 3) != 0);
      res_n  = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 7) == 0) mode = MODE_W'($urandom);
      ram_en = $urandom_range(0, 1);
      tick_n($urandom_range(1, 70));
    end
    finish_run();
  end

endmodule